// File: doc/BRIEF.md
# Short Full-Duplex SPI Shifter

This block is a small SPI master engine for generic full-duplex exchanges of one to six bytes with a single slave. It uses one chip select, one data line in each direction, and no flash-specific opcodes. Software fills six byte-wide transmit slots and writes a bit count into the length register. Writing a 1 to the start bit of the command register begins the exchange. The engine frames the exchange with chip select, clocks the bits out in SPI mode 0, and collects the incoming bits into six receive slots. It clears the start bit when the exchange is complete.

The transmit slots are consumed from the highest index downward. The receive slots fill in the mirror order: the last byte received lands in slot 0, and the first byte of an N-byte exchange lands in slot N-1. The serial clock runs at a fixed integer division of the system clock.

The controller has four states:
- `ST_IDLE`: chip select high, clock low.
- `ST_LEAD`: chip select low for one serial clock period before the first edge.
- `ST_SHIFT`: the clock toggles once every half period.
- `ST_TRAIL`: chip select held low for one period after the last falling edge.

The transitions are:
- IDLE→LEAD on a start write.
- LEAD→SHIFT on the second half-period tick, or LEAD→TRAIL on that tick when the length is zero.
- SHIFT→TRAIL on the falling edge that completes the last bit.
- TRAIL→IDLE on the second tick.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, chip select is high, the serial clock and MOSI are low, and the command, length and receive-slot registers all read 0.
- R2: Writing the command register (address 0) with bit 2 set while idle starts an exchange. Bit 2 reads 1 while busy and returns to 0 by itself when chip select is released.
- R3: Bytes go out from transmit slot 5 first, then slot 4, and so on down to slot 0, each byte MSB first. Transmit slot k is at address 2+k.
- R4: The length register (address 1) is a bit count, and an exchange makes exactly that many rising clock edges. Values above 48 are treated as 48.
- R5: After an N-byte exchange, receive slot N-1-j (address 8+N-1-j) holds the j-th byte received, with the first byte at j=0. Receive slots at N and above read 0.
- R6: SPI mode 0 is used. The clock idles low, MOSI changes only on falling edges or at the frame boundary, and MISO is sampled on rising edges.
- R7: Chip select goes low one full serial clock period before the first rising edge. It goes high one full period after the last falling edge.
- R8: Transmit slots that were never written hold 0, so their bytes go out as zero.
- R9: Writes to the transmit slots, the length register or the command register are ignored while busy.
- R10: Each serial clock half period lasts exactly DIV_HALF system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe for one cycle |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from reg_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
Each fault shows up at the pins, and most show up within one serial clock period:
- A wrong state or a stale half-period flag makes the lead or trail window longer or shorter, which is seen at the first rising edge or at chip-select release.
- A miscounted bit counter changes the number of rising edges and leaves bytes missing from, or extra in, the scoreboard queue.
- A shifter loaded or read in the wrong order appears as the first MOSI byte not matching slot 5.
- A receive slot landing mirrored the wrong way appears on the first slot read after completion.
- A busy flag that is not honoured lets a poke during the exchange change the register readback, or restart the frame.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL
    } xfer_state_t;

    localparam int unsigned SLOTS     = 6;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned MAX_BITS  = SLOTS * BYTE_W;
    localparam int unsigned LEN_W     = $clog2(MAX_BITS + 1);

    localparam int unsigned ADDR_CMD  = 0;
    localparam int unsigned ADDR_LEN  = 1;
    localparam int unsigned ADDR_TX0  = 2;
    localparam int unsigned ADDR_RX0  = ADDR_TX0 + SLOTS;
    localparam int unsigned START_BIT = 2;

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int unsigned DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_burst_regs.sv
module spi_burst_regs
    import spi_burst_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                busy,
    input  logic [MAX_BITS-1:0] rx_flat,
    output logic [MAX_BITS-1:0] tx_flat,
    output logic [LEN_W-1:0]    len_eff,
    output logic                start,
    output logic [DATA_W-1:0]   rdata
);
    logic [BYTE_W-1:0] tx_slot [SLOTS];
    logic [DATA_W-1:0] len_q;
    logic              wr_ok;

    assign wr_ok = wr_en && !busy;
    assign start = wr_ok && (addr == ADDR_W'(ADDR_CMD)) && wdata[START_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (wr_ok && (addr == ADDR_W'(ADDR_LEN))) begin
            len_q <= wdata;
        end
    end

    assign len_eff = (len_q > DATA_W'(MAX_BITS)) ? LEN_W'(MAX_BITS) : LEN_W'(len_q);

    for (genvar g = 0; g < SLOTS; g++) begin : g_tx
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tx_slot[g] <= '0;
            end else if (wr_ok && (addr == ADDR_W'(ADDR_TX0 + g))) begin
                tx_slot[g] <= wdata[BYTE_W-1:0];
            end
        end
        assign tx_flat[g*BYTE_W +: BYTE_W] = tx_slot[g];
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_CMD)) begin
            rdata[START_BIT] = busy;
        end
        if (addr == ADDR_W'(ADDR_LEN)) begin
            rdata = len_q;
        end
        for (int k = 0; k < SLOTS; k++) begin
            if (addr == ADDR_W'(ADDR_TX0 + k)) begin
                rdata = DATA_W'(tx_slot[k]);
            end
            if (addr == ADDR_W'(ADDR_RX0 + k)) begin
                rdata = DATA_W'(rx_flat[k*BYTE_W +: BYTE_W]);
            end
        end
    end
endmodule

// File: rtl/spi_burst_fsm.sv
module spi_burst_fsm
    import spi_burst_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                start,
    input  logic [MAX_BITS-1:0] tx_flat,
    input  logic [LEN_W-1:0]    len_bits,
    input  logic                miso,
    output logic                sclk,
    output logic                mosi,
    output logic                cs_n,
    output logic                busy,
    output logic [MAX_BITS-1:0] rx_flat
);
    xfer_state_t         state_q, state_d;
    logic                half_q;
    logic [LEN_W-1:0]    len_q;
    logic [LEN_W-1:0]    cnt_q;
    logic [MAX_BITS-1:0] tx_q;
    logic [MAX_BITS-1:0] rx_q;
    logic                last_fall;

    assign last_fall = (LEN_W'(cnt_q + 1'b1) == len_q);
    assign busy      = (state_q != ST_IDLE);
    assign mosi      = busy && tx_q[MAX_BITS-1];
    assign rx_flat   = rx_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LEAD;
            ST_LEAD:  if (tick && half_q) state_d = (len_q == '0) ? ST_TRAIL : ST_SHIFT;
            ST_SHIFT: if (tick && sclk && last_fall) state_d = ST_TRAIL;
            ST_TRAIL: if (tick && half_q) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk   <= 1'b0;
            cs_n   <= 1'b1;
            half_q <= 1'b0;
            len_q  <= '0;
            cnt_q  <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    sclk <= 1'b0;
                    if (start) begin
                        cs_n   <= 1'b0;
                        half_q <= 1'b0;
                        cnt_q  <= '0;
                        len_q  <= len_bits;
                        tx_q   <= tx_flat;
                        rx_q   <= '0;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        half_q <= ~half_q;
                        if (half_q && (len_q != '0)) begin
                            sclk <= 1'b1;
                            rx_q <= {rx_q[MAX_BITS-2:0], miso};
                        end
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sclk) begin
                            sclk <= 1'b1;
                            rx_q <= {rx_q[MAX_BITS-2:0], miso};
                        end else begin
                            sclk  <= 1'b0;
                            cnt_q <= LEN_W'(cnt_q + 1'b1);
                            if (!last_fall) begin
                                tx_q <= {tx_q[MAX_BITS-2:0], 1'b0};
                            end
                        end
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        half_q <= ~half_q;
                        if (half_q) begin
                            cs_n <= 1'b1;
                        end
                    end
                end
                default: begin
                    sclk <= 1'b0;
                    cs_n <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
    import spi_burst_pkg::*;
#(
    parameter int unsigned DIV_HALF = 4,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    logic                busy_w;
    logic                tick_w;
    logic                start_w;
    logic [MAX_BITS-1:0] tx_w;
    logic [MAX_BITS-1:0] rx_w;
    logic [LEN_W-1:0]    len_w;

    spi_burst_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .busy    (busy_w),
        .rx_flat (rx_w),
        .tx_flat (tx_w),
        .len_eff (len_w),
        .start   (start_w),
        .rdata   (reg_rdata)
    );

    spi_half_tick #(
        .DIV_HALF (DIV_HALF)
    ) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy_w),
        .tick  (tick_w)
    );

    spi_burst_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_w),
        .start    (start_w),
        .tx_flat  (tx_w),
        .len_bits (len_w),
        .miso     (spi_miso),
        .sclk     (spi_sclk),
        .mosi     (spi_mosi),
        .cs_n     (spi_cs_n),
        .busy     (busy_w),
        .rx_flat  (rx_w)
    );
endmodule

// File: rtl/spi_burst_checker.sv
module spi_burst_checker (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic mosi,
    input logic cs_n,
    input logic busy
);
    assert_clk_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    assert_mosi_steady_at_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));

    assert_lead_no_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |=> !sclk);

    assert_frame_starts_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $fell(cs_n));

    assert_frame_ends_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $rose(cs_n));

    assert_idle_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);
endmodule

bind spi_burst_master spi_burst_checker chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .sclk  (spi_sclk),
    .mosi  (spi_mosi),
    .cs_n  (spi_cs_n),
    .busy  (busy_w)
);

// File: tb/spi_burst_master_tb_top.sv
module spi_burst_master_tb_top;
    localparam int DIV     = 3;
    localparam int HALF_NS = DIV * 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       spi_sclk, spi_mosi, spi_cs_n;
    logic       spi_miso = 1'b0;

    always #4 clk = ~clk;

    spi_burst_master #(.DIV_HALF(DIV), .ADDR_W(4), .DATA_W(8)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .spi_sclk  (spi_sclk),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .spi_cs_n  (spi_cs_n)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // scoreboard and slave model
    logic [7:0]  exp_q[$];
    string       sb_req = "R3";
    logic [47:0] miso_pat = '0;
    logic [47:0] slave_sh = '0;
    logic [7:0]  mon_sh = '0;
    int          mon_bits = 0;
    int          rise_cnt = 0;
    bit          first_rise = 0;
    bit          half_ok = 1;
    time         t_cs_fall = 0, t_last_rise = 0, t_last_fall = 0;
    time         lead_ns = 0, trail_ns = 0;
    logic        cs_prev = 1'b1, sclk_prev = 1'b0;

    always @(spi_cs_n or spi_sclk) begin
        time t;
        t = $time;
        if (rst_n && (spi_cs_n !== cs_prev)) begin
            if (!spi_cs_n) begin
                t_cs_fall  = t;
                first_rise = 1;
                rise_cnt   = 0;
                mon_bits   = 0;
                half_ok    = 1;
                slave_sh   = miso_pat;
                spi_miso   = slave_sh[47];
            end else begin
                trail_ns = t - t_last_fall;
            end
        end
        if (rst_n && (spi_sclk !== sclk_prev)) begin
            if (spi_sclk) begin
                if (first_rise) begin
                    lead_ns    = t - t_cs_fall;
                    first_rise = 0;
                end else if (t - t_last_fall != HALF_NS) begin
                    half_ok = 0;
                end
                t_last_rise = t;
                rise_cnt++;
                mon_sh = {mon_sh[6:0], spi_mosi};
                mon_bits++;
                if (mon_bits == 8) begin
                    mon_bits = 0;
                    if (exp_q.size() == 0) check(sb_req, "unexpected mosi byte", {56'd0, mon_sh}, 64'hFFFF);
                    else check(sb_req, "mosi byte", {56'd0, mon_sh}, {56'd0, exp_q.pop_front()});
                end
            end else begin
                if (t - t_last_rise != HALF_NS) half_ok = 0;
                t_last_fall = t;
                slave_sh = {slave_sh[46:0], 1'b0};
                spi_miso = slave_sh[47];
            end
        end
        cs_prev   = spi_cs_n;
        sclk_prev = spi_sclk;
    end

    task automatic bus_write(input int a, input int d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = 4'(a);
        reg_wdata = 8'(d);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic bus_read(input int a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = 4'(a);
        #1 d = reg_rdata;
    endtask

    // tx_img[8k+:8] is transmit slot k; write_tx=0 means the slots already hold tx_img
    task automatic do_xfer(string req, input logic [47:0] tx_img, input bit write_tx,
                           input int len_wr, input logic [47:0] pat, input bit poke);
        logic [7:0] rd;
        int eff, nb, polls;
        if (write_tx) for (int k = 0; k < 6; k++) bus_write(2 + k, int'(tx_img[8*k +: 8]));
        bus_write(1, len_wr);
        miso_pat = pat;
        sb_req   = req;
        eff = (len_wr > 48) ? 48 : len_wr;
        nb  = eff / 8;
        for (int j = 0; j < nb; j++) exp_q.push_back(tx_img[47 - 8*j -: 8]);
        bus_write(0, 8'h04);
        bus_read(0, rd);
        check("R2", "busy bit after start", {63'd0, rd[2]}, 64'd1);
        if (poke) begin
            bus_write(7, 8'hEE);
            bus_write(1, 8);
            bus_write(0, 8'h04);
        end
        polls = 0;
        do begin
            bus_read(0, rd);
            polls++;
        end while (rd[2] && polls < 5000);
        check("R2", "busy clears by itself", {63'd0, rd[2]}, 64'd0);
        repeat (4) @(negedge clk);
        check("R2", "cs released after completion", {63'd0, spi_cs_n}, 64'd1);
        check("R6", "clock idles low", {63'd0, spi_sclk}, 64'd0);
        check(req, "bytes left in scoreboard", 64'(exp_q.size()), 64'd0);
        exp_q.delete();
        check("R4", "rising edge count", 64'(rise_cnt), 64'(eff));
        check("R7", "lead time ns", 64'(lead_ns), 64'(2*HALF_NS));
        check("R7", "trail time ns", 64'(trail_ns), 64'(2*HALF_NS));
        check("R10", "half periods", {63'd0, half_ok}, 64'd1);
        for (int k = 0; k < 6; k++) begin
            logic [7:0] e;
            e = (k < nb) ? pat[47 - 8*(nb-1-k) -: 8] : 8'h00;
            bus_read(8 + k, rd);
            check("R5", $sformatf("rx slot %0d", k), {56'd0, rd}, {56'd0, e});
        end
        if (poke) begin
            bus_read(7, rd);
            check("R9", "tx slot 5 unchanged", {56'd0, rd}, {56'd0, tx_img[47:40]});
            bus_read(1, rd);
            check("R9", "length unchanged", {56'd0, rd}, 64'(len_wr));
            repeat (10) @(negedge clk);
            check("R9", "no restart from busy start write", {63'd0, spi_cs_n}, 64'd1);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] rd;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "cs_n", {63'd0, spi_cs_n}, 64'd1);
        check("R1", "sclk", {63'd0, spi_sclk}, 64'd0);
        check("R1", "mosi", {63'd0, spi_mosi}, 64'd0);
        bus_read(0, rd); check("R1", "command", {56'd0, rd}, 64'd0);
        bus_read(1, rd); check("R1", "length", {56'd0, rd}, 64'd0);
        bus_read(8, rd); check("R1", "rx slot 0", {56'd0, rd}, 64'd0);
        // R8: never-written slots send zeros
        do_xfer("R8", 48'h0, 0, 16, 48'hA5C3_0000_0000, 0);
        // R3/R5: full six bytes
        do_xfer("R3", 48'h1122_3344_5566, 1, 48, 48'h9ABC_DEF0_1234, 0);
        // R3/R5: three bytes uses slots 5..3
        do_xfer("R3", 48'hC0FF_EE01_0203, 1, 24, 48'h5A69_9600_0000, 0);
        // R4: length above limit clamps
        do_xfer("R4", 48'h8001_7F02_FE03, 1, 60, 48'h0F1E_2D3C_4B5A, 0);
        // R9: writes while busy ignored
        do_xfer("R9", 48'h3141_5926_5358, 1, 40, 48'hDEAD_BEEF_CAFE, 1);
        done = 1;
        summary();
    end
endmodule